// File: doc/BRIEF.md
# Idle-Aware Hinted Clock Gate Bank

This block gates five clocks, one for each of five transactional units (an AES engine, an HMAC engine, a KMAC engine, a crypto unit on the divided IO clock and a crypto unit on the main clock). Software sets a per-unit hint bit to ask for a clock to be turned off. The gate stays open while the unit still reports work in progress. Each gate also needs the power-manager enable of the root clock it is fed from. A scan-test override opens every gate regardless of the other controls.

The hint bits come from the register clock domain. In each unit's root clock domain they pass through a two-stage synchroniser, which resets to "run". The gate decision feeds a latch that is transparent while the root clock is low, and the root clock is ANDed with the latch output, so pulses are never cut short. The enable of each gate is carried back to the register domain through a two-stage synchroniser and read there as a status vector.

Top module: `clkgate_top`

## Requirements
- R1: There are five units with independent controls. Bit i of `hint_i`, `idle_i`, `gclk_o` and `status_o` belongs to unit i. Units 0, 1, 2 and 4 are fed from `clk_main_i` and enabled by `main_en_i`. Unit 3 is fed from `clk_io_i` and enabled by `io_en_i`.
- R2: While a unit's `idle_i` bit is 0 (busy) and its root enable is 1, its gated clock runs, whatever its hint bit is.
- R3: When a unit's synchronised hint bit is 0, its `idle_i` bit is 1 and scan override is off, its gated clock is held low.
- R4: When a unit's root enable is 0 and scan override is off, its gated clock is held low, whatever the hint and idle bits are.
- R5: Scan override is on only when `scan_i` equals 4'h6. It then makes every gated clock run, with no clock edge needed for the decision. Every other `scan_i` value has no effect.
- R6: A hint change reaches the gate through two flops clocked by the unit's root clock. After a change, exactly two more root rising edges pass with the old hint in force. The synchroniser resets to 1, so every clock whose root is enabled runs during and after reset.
- R7: `status_o` bit i equals unit i's gate enable, delayed by two `clk_i` rising edges. It resets to all ones.
- R8: While a gate is enabled, every rising edge of its root clock produces exactly one full gated pulse. While it is disabled, no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register-domain clock |
| clk_main_i | input | 1 | Main root clock |
| clk_io_i | input | 1 | Divided IO root clock |
| rst_i | input | 1 | Synchronous active-high reset, held over several cycles of every clock |
| hint_i | input | 5 | Software hint per unit, 1 = keep running, 0 = may stop |
| idle_i | input | 5 | Per-unit idle flag, 1 = idle, 0 = busy (root-clock domain) |
| main_en_i | input | 1 | Power-manager enable of the main root |
| io_en_i | input | 1 | Power-manager enable of the IO root |
| scan_i | input | 4 | Multi-bit scan override, true only at 4'h6 |
| gclk_o | output | 5 | Gated unit clocks |
| status_o | output | 5 | Gate enables synchronised into the register domain |

## Verification
The hardest behaviour to pin down from the ports is the exact synchroniser depth. A hint change must let exactly two more gated pulses through, and a hint set must hold the gate shut for the first two root edges. Neither shows up in a pass/fail clock-running test. The stimulus drives every input on register-clock edges whose times never coincide with a root-clock edge. It then counts gated rising edges in short windows after a hint toggle. The IO-root unit is used for this, because its period lets the window contain at most two root edges. The same edge counters, compared against root-clock edge counts, show that no pulse is split or dropped while a gate is open.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    localparam int UNIT_COUNT = 5;

    typedef logic [3:0] mubi4_t;
    localparam mubi4_t MUBI4_ON = 4'h6;

    typedef enum logic {
        ROOT_MAIN = 1'b0,
        ROOT_IO   = 1'b1
    } root_sel_e;

    // Only the single encoded value counts as true.
    function automatic logic mubi4_on(mubi4_t v);
        return v == MUBI4_ON;
    endfunction

    // Gate decision shared by every unit.
    function automatic logic gate_decision(logic scan_on, logic root_en,
                                           logic hint, logic idle);
        return scan_on | (root_en & (hint | ~idle));
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
`timescale 1ns/1ps
module clkgate_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/clkgate_cell.sv
`timescale 1ns/1ps
module clkgate_cell (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o,
    output logic en_held_o
);
    logic en_held;

    // Transparent while the clock is low; frozen through the high phase.
    always_latch begin
        if (!clk_i) en_held = en_i;
    end

    assign gclk_o    = clk_i & en_held;
    assign en_held_o = en_held;
endmodule

// File: rtl/clkgate_unit.sv
`timescale 1ns/1ps
module clkgate_unit
    import clkgate_pkg::*;
(
    input  logic clk_root_i,
    input  logic rst_i,
    input  logic hint_i,
    input  logic idle_i,
    input  logic root_en_i,
    input  logic scan_on_i,
    output logic gclk_o,
    output logic en_o,
    output logic gate_on_o,
    output logic hint_q_o
);
    logic hint_q;
    logic en;

    clkgate_sync #(.W(1), .RST_VAL(1'b1)) u_hint_sync (
        .clk_i (clk_root_i),
        .rst_i (rst_i),
        .d_i   (hint_i),
        .q_o   (hint_q)
    );

    assign en = gate_decision(scan_on_i, root_en_i, hint_q, idle_i);

    clkgate_cell u_cell (
        .clk_i     (clk_root_i),
        .en_i      (en),
        .gclk_o    (gclk_o),
        .en_held_o (gate_on_o)
    );

    assign en_o     = en;
    assign hint_q_o = hint_q;
endmodule

// File: rtl/clkgate_top.sv
`timescale 1ns/1ps
module clkgate_top
    import clkgate_pkg::*;
#(
    parameter int                  N          = UNIT_COUNT,
    parameter logic [N-1:0]        ROOT_IS_IO = 5'b01000
) (
    input  logic         clk_i,
    input  logic         clk_main_i,
    input  logic         clk_io_i,
    input  logic         rst_i,
    input  logic [N-1:0] hint_i,
    input  logic [N-1:0] idle_i,
    input  logic         main_en_i,
    input  logic         io_en_i,
    input  logic [3:0]   scan_i,
    output logic [N-1:0] gclk_o,
    output logic [N-1:0] status_o
);
    logic         scan_on;
    logic [N-1:0] en_w;
    logic [N-1:0] gate_on_w;
    logic [N-1:0] hint_q_w;

    assign scan_on = mubi4_on(mubi4_t'(scan_i));

    for (genvar g = 0; g < N; g++) begin : g_unit
        logic unit_clk;
        logic unit_en;

        if (root_sel_e'(ROOT_IS_IO[g]) == ROOT_IO) begin : g_io
            assign unit_clk = clk_io_i;
            assign unit_en  = io_en_i;
        end else begin : g_main
            assign unit_clk = clk_main_i;
            assign unit_en  = main_en_i;
        end

        clkgate_unit u_unit (
            .clk_root_i (unit_clk),
            .rst_i      (rst_i),
            .hint_i     (hint_i[g]),
            .idle_i     (idle_i[g]),
            .root_en_i  (unit_en),
            .scan_on_i  (scan_on),
            .gclk_o     (gclk_o[g]),
            .en_o       (en_w[g]),
            .gate_on_o  (gate_on_w[g]),
            .hint_q_o   (hint_q_w[g])
        );
    end

    clkgate_sync #(.W(N), .RST_VAL({N{1'b1}})) u_status_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (en_w),
        .q_o   (status_o)
    );
endmodule

// File: rtl/clkgate_chk.sv
`timescale 1ns/1ps
module clkgate_chk #(
    parameter int           N          = 5,
    parameter logic [N-1:0] ROOT_IS_IO = 5'b01000
) (
    input logic         clk_i,
    input logic         clk_main_i,
    input logic         clk_io_i,
    input logic         rst_i,
    input logic [N-1:0] hint_i,
    input logic [N-1:0] idle_i,
    input logic         main_en_i,
    input logic         io_en_i,
    input logic [3:0]   scan_i,
    input logic [N-1:0] status_o,
    input logic [N-1:0] gate_on,
    input logic [N-1:0] hint_q
);
    logic scan_true;
    assign scan_true = (scan_i == 4'h6);

    for (genvar g = 0; g < N; g++) begin : g_chk
        logic rclk;
        logic ren;
        assign rclk = ROOT_IS_IO[g] ? clk_io_i : clk_main_i;
        assign ren  = ROOT_IS_IO[g] ? io_en_i  : main_en_i;

        // R2
        a_r2_busy_keeps_running: assert property (@(posedge rclk) disable iff (rst_i)
            (ren && !idle_i[g]) |-> gate_on[g]);

        // R3
        a_r3_idle_hint_stops: assert property (@(posedge rclk) disable iff (rst_i)
            (!scan_true && idle_i[g] && !hint_q[g]) |-> !gate_on[g]);

        // R4
        a_r4_root_off_stops: assert property (@(posedge rclk) disable iff (rst_i)
            (!scan_true && !ren) |-> !gate_on[g]);

        // R5
        a_r5_scan_forces_run: assert property (@(posedge rclk) disable iff (rst_i)
            scan_true |-> gate_on[g]);

        // R6
        a_r6_two_stage_hint: assert property (@(posedge rclk) disable iff (rst_i)
            (!$past(rst_i, 1) && !$past(rst_i, 2)) |-> (hint_q[g] == $past(hint_i[g], 2)));
    end

    // R7
    a_r7_status_follows_scan: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i, 1) && !$past(rst_i, 2) && $past(scan_true, 1) && $past(scan_true, 2))
        |-> (status_o == {N{1'b1}}));
endmodule

bind clkgate_top clkgate_chk #(.N(N), .ROOT_IS_IO(ROOT_IS_IO)) u_chk (
    .clk_i      (clk_i),
    .clk_main_i (clk_main_i),
    .clk_io_i   (clk_io_i),
    .rst_i      (rst_i),
    .hint_i     (hint_i),
    .idle_i     (idle_i),
    .main_en_i  (main_en_i),
    .io_en_i    (io_en_i),
    .scan_i     (scan_i),
    .status_o   (status_o),
    .gate_on    (gate_on_w),
    .hint_q     (hint_q_w)
);

// File: tb/clkgate_top_test.sv
`timescale 1ns/1ps
module clkgate_top_test;
    localparam int N = 5;

    logic         clk_i = 1'b0;
    logic         clk_main_i = 1'b0;
    logic         clk_io_i = 1'b0;
    logic         rst_i = 1'b1;
    logic [N-1:0] hint_i = '0;
    logic [N-1:0] idle_i = '1;
    logic         main_en_i = 1'b1;
    logic         io_en_i = 1'b1;
    logic [3:0]   scan_i = 4'h0;
    logic [N-1:0] gclk_o;
    logic [N-1:0] status_o;

    int checks = 0;
    int errors = 0;

    clkgate_top uut (
        .clk_i(clk_i), .clk_main_i(clk_main_i), .clk_io_i(clk_io_i), .rst_i(rst_i),
        .hint_i(hint_i), .idle_i(idle_i), .main_en_i(main_en_i), .io_en_i(io_en_i),
        .scan_i(scan_i), .gclk_o(gclk_o), .status_o(status_o)
    );

    // 125 MHz register clock; root edges sit on half-ns offsets so they never
    // coincide with the integer times at which inputs are driven.
    always #4 clk_i = ~clk_i;
    initial begin #0.5; forever #3 clk_main_i = ~clk_main_i; end
    initial begin #1.5; forever #5 clk_io_i = ~clk_io_i; end

    int c0 = 0, c1 = 0, c2 = 0, c3 = 0, c4 = 0, cm = 0, cio = 0;
    always @(posedge gclk_o[0]) c0++;
    always @(posedge gclk_o[1]) c1++;
    always @(posedge gclk_o[2]) c2++;
    always @(posedge gclk_o[3]) c3++;
    always @(posedge gclk_o[4]) c4++;
    always @(posedge clk_main_i) cm++;
    always @(posedge clk_io_i) cio++;

    int d[N];
    int d_main, d_io;
    int s[N];
    int s_main, s_io;

    function automatic int gcount(int i);
        case (i)
            0: return c0;
            1: return c1;
            2: return c2;
            3: return c3;
            default: return c4;
        endcase
    endfunction

    task automatic snap_start();
        for (int i = 0; i < N; i++) s[i] = gcount(i);
        s_main = cm;
        s_io = cio;
    endtask

    task automatic snap_end();
        for (int i = 0; i < N; i++) d[i] = gcount(i) - s[i];
        d_main = cm - s_main;
        d_io = cio - s_io;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(logic [N-1:0] h, logic [N-1:0] idl, logic me, logic ie, logic [3:0] sc);
        @(negedge clk_i);
        hint_i = h; idle_i = idl; main_en_i = me; io_en_i = ie; scan_i = sc;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk_i);
    endtask

    // Independent model of the gate decision from the requirements.
    function automatic logic [N-1:0] model_run();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            logic root;
            root = (i == 3) ? io_en_i : main_en_i;
            r[i] = (scan_i == 4'h6) | (root & (hint_i[i] | ~idle_i[i]));
        end
        return r;
    endfunction

    task automatic expect_run(logic [N-1:0] mask, string req);
        snap_start();
        repeat (20) @(negedge clk_i);
        snap_end();
        for (int i = 0; i < N; i++) begin
            if (mask[i]) check(d[i] > 8, req, $sformatf("unit %0d pulses (running)", i), d[i], 9);
            else         check(d[i] == 0, req, $sformatf("unit %0d pulses (stopped)", i), d[i], 0);
        end
        check(status_o == mask, req, "status_o", int'(status_o), int'(mask));
    endtask

    task automatic t_reset();
        // R6: synchroniser resets to 1, so clocks run while reset holds hint at 0.
        repeat (3) @(negedge clk_i);
        snap_start();
        repeat (20) @(negedge clk_i);
        snap_end();
        for (int i = 0; i < N; i++)
            check(d[i] > 8, "R6", $sformatf("unit %0d runs in reset", i), d[i], 9);
        check(status_o == 5'h1f, "R7", "status_o in reset", int'(status_o), 31);
        hint_i = 5'h1f;
        @(negedge clk_i);
        rst_i = 1'b0;
        settle();
        expect_run(5'h1f, "R6");
    endtask

    task automatic t_pulse();
        drive(5'h1f, 5'h1f, 1'b1, 1'b1, 4'h0);
        settle();
        snap_start();
        repeat (25) @(negedge clk_i);
        snap_end();
        check(d[0] == d_main, "R8", "unit 0 pulses vs main edges", d[0], d_main);
        check(d[4] == d_main, "R8", "unit 4 pulses vs main edges", d[4], d_main);
        check(d[3] == d_io, "R8", "unit 3 pulses vs io edges", d[3], d_io);
    endtask

    task automatic t_idle_stop();
        drive(5'h00, 5'h1f, 1'b1, 1'b1, 4'h0);
        settle();
        expect_run(5'h00, "R3");
    endtask

    task automatic t_busy();
        drive(5'h00, 5'b10101, 1'b1, 1'b1, 4'h0);
        settle();
        expect_run(model_run(), "R2");
        check(model_run() == 5'b01010, "R2", "model mask", int'(model_run()), 10);
        drive(5'h00, 5'b01010, 1'b1, 1'b1, 4'h0);
        settle();
        expect_run(5'b10101, "R2");
    endtask

    task automatic t_indep();
        drive(5'b10010, 5'h1f, 1'b1, 1'b1, 4'h0);
        settle();
        expect_run(5'b10010, "R1");
    endtask

    task automatic t_root();
        drive(5'h1f, 5'b00000, 1'b0, 1'b1, 4'h0);
        settle();
        expect_run(5'b01000, "R4");
        drive(5'h1f, 5'b00000, 1'b1, 1'b0, 4'h0);
        settle();
        expect_run(5'b10111, "R1");
    endtask

    task automatic t_scan();
        drive(5'h00, 5'h1f, 1'b0, 1'b0, 4'h6);
        settle();
        expect_run(5'h1f, "R5");
        drive(5'h00, 5'h1f, 1'b0, 1'b0, 4'h9);
        settle();
        expect_run(5'h00, "R5");
        drive(5'h00, 5'h1f, 1'b1, 1'b1, 4'hE);
        settle();
        expect_run(5'h00, "R5");
        drive(5'h00, 5'h1f, 1'b1, 1'b1, 4'h0);
        settle();
        expect_run(5'h00, "R5");
    endtask

    task automatic t_sync_depth();
        drive(5'h1f, 5'h1f, 1'b1, 1'b1, 4'h0);
        settle();
        @(negedge clk_i);
        hint_i = 5'h00;
        snap_start();
        repeat (10) @(negedge clk_i);
        snap_end();
        check(d[3] == 2, "R6", "unit 3 pulses after hint clear", d[3], 2);
        check(d[0] == 2, "R6", "unit 0 pulses after hint clear", d[0], 2);
        // Gate shut: setting the hint needs two root edges before the first pulse.
        @(negedge clk_i);
        hint_i = 5'h1f;
        snap_start();
        repeat (2) @(negedge clk_i);
        snap_end();
        check(d[3] == 0, "R6", "unit 3 pulses within two io edges of hint set", d[3], 0);
        settle();
        expect_run(5'h1f, "R6");
    endtask

    task automatic t_status_latency();
        drive(5'h00, 5'h1f, 1'b1, 1'b1, 4'h0);
        settle();
        @(negedge clk_i);
        scan_i = 4'h6;
        @(posedge clk_i); #1;
        check(status_o == 5'h00, "R7", "status after one edge", int'(status_o), 0);
        @(posedge clk_i); #1;
        check(status_o == 5'h1f, "R7", "status after two edges", int'(status_o), 31);
        drive(5'h00, 5'h1f, 1'b1, 1'b1, 4'h0);
        settle();
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_pulse();
        t_idle_stop();
        t_busy();
        t_indep();
        t_root();
        t_scan();
        t_sync_depth();
        t_status_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule